// File: doc/BRIEF.md
# Infrared Remote Frame End Detector

This block decides when an infrared remote-control data frame has finished arriving. It sits behind the demodulator and the leader decoder. It watches the demodulated receive line, where each data bit begins with a falling edge. A prescaled time-base tick is its only unit of time. Once a leader has been recognised upstream, the block counts data bits and times the gaps between falling edges. It also times how long the line stays low.

Reception can end in one of two ways. The first is a maximum bit-cycle timeout: no new falling edge arrives within a programmed number of ticks after the previous one. This timeout is a valid completion only if the number of bits received equals one of several programmable end counts, which lets the receiver accept frames of different lengths. If the count matches none of them, the block returns to waiting for a leader without raising an interrupt. The second way is an excess-low timeout: the line stays low longer than a programmed width. This timeout always completes reception. Whichever cause is detected first ends the frame. A completion produces a one-cycle interrupt pulse and sets a sticky status flag for its cause.

Top module: `ir_rx_end_detect`

## Requirements
- R1: After reset, busy_o, irq_o, stat_max_o and stat_low_o are 0, and bit_cnt_o is 0.
- R2: A one-cycle high on leader_i has priority over every other input. It sets busy_o on the next cycle, clears bit_cnt_o to 0 and restarts both timers. This holds even in the middle of a frame. While busy_o is 0 and no leader arrives, busy_o stays 0, irq_o stays 0 and bit_cnt_o stays unchanged.
- R3: While busy_o is 1, a data-bit falling edge is a cycle where rx_i is 0 and rx_i was 1 in the previous cycle. bit_cnt_o counts every such edge after the first one since the leader, so N bits produce N+1 edges. The count saturates at 255.
- R4: The bit-cycle timer starts at the first data-bit falling edge and restarts on each later one. The falling-edge cycle itself is not counted. A maximum-cycle event occurs on the max_cycle_i-th tick after the last falling edge, and only if max_en_i is 1. A threshold of 0 never produces the event.
- R5: At a maximum-cycle event, if bit_cnt_o equals any nonzero entry of end_cnt_i, the block does three things on the next clock edge. It returns to idle (busy_o goes to 0), pulses irq_o and sets stat_max_o.
- R6: At a maximum-cycle event where bit_cnt_o matches no end count, busy_o goes to 0. irq_o stays 0, and neither status flag is set.
- R7: An end_cnt_i entry of 0 disables that comparator, so a count of 0 never matches it.
- R8: The low timer counts ticks while rx_i is 0 and busy_o is 1. It holds its value while rx_i is 1. It restarts on every falling edge and on the leader. When it reaches low_width_i ticks and low_en_i is 1, the block completes whatever the bit count: busy_o goes to 0, irq_o pulses and stat_low_o is set.
- R9: The first completion cause to be detected ends reception. If both causes occur in the same cycle, the maximum-cycle event wins and the match rules of R5 and R6 apply.
- R10: stat_max_o and stat_low_o stay at 1 until a 1 is written to their clear bits, which are stat_clr_i[0] and stat_clr_i[1] respectively. Clearing one flag leaves the other unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R11: irq_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Demodulated receive line; a falling edge starts a data bit |
| tick_i | input | 1 | Prescaled time-base tick, one cycle wide |
| leader_i | input | 1 | One-cycle pulse from the leader decoder |
| max_en_i | input | 1 | Enables completion by maximum bit cycle |
| low_en_i | input | 1 | Enables completion by excess low width |
| max_cycle_i | input | TIME_W | Maximum bit-cycle threshold, in ticks |
| low_width_i | input | TIME_W | Excess-low threshold, in ticks |
| end_cnt_i | input | NUM_END x CNT_W | End bit counts; 0 disables an entry |
| stat_clr_i | input | 2 | Write-one-to-clear: bit 0 clears stat_max_o, bit 1 clears stat_low_o |
| irq_o | output | 1 | One-cycle completion interrupt |
| stat_max_o | output | 1 | Sticky flag: completed by maximum bit cycle |
| stat_low_o | output | 1 | Sticky flag: completed by excess low width |
| busy_o | output | 1 | Reception in progress |
| bit_cnt_o | output | CNT_W | Received bit count; held after completion |

## Verification
The bench drives frames whose lengths hit the second and third end comparators. It also sends lengths that match none of them. A design that ignored the count check would interrupt on the mismatched frames. One frame has zero bits while an end entry is 0; a design that compared zero entries would report completion there. The line is held low past the last edge with the two thresholds set both different and equal. This exposes wrong cause ordering and a wrong tie-break. A 300-bit frame checks that the counter saturates at 255 rather than wrapping. The bench measures the distance from the last edge to completion, which catches off-by-one tick counting. It also checks that a leader mid-frame discards the partial count, that a zero or disabled threshold never ends reception, and that each flag clears independently.

// File: rtl/ir_end_pkg.sv
package ir_end_pkg;
  typedef enum logic {
    ST_WAIT_LEADER = 1'b0,
    ST_RECV        = 1'b1
  } rx_state_e;

  localparam int unsigned CLR_MAX_BIT = 0;
  localparam int unsigned CLR_LOW_BIT = 1;
endpackage

// File: rtl/ir_fall_det.sv
module ir_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/ir_tick_timer.sv
module ir_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic         en_i,
  input  logic [W-1:0] thr_i,
  output logic         hit_o
);
  localparam logic [W-1:0] SAT = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != SAT)   cnt_q <= cnt_nxt[W-1:0];
  end

  // fires on the tick that brings the count up to the threshold
  assign hit_o = en_i & run_i & ~clear_i & (thr_i != '0) & (cnt_nxt == {1'b0, thr_i});
endmodule

// File: rtl/ir_bit_counter.sv
module ir_bit_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned NUM_END = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic                           inc_i,
  input  logic [NUM_END-1:0][CNT_W-1:0]  end_cnt_i,
  output logic [CNT_W-1:0]               cnt_o,
  output logic                           match_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_END-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (inc_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_END; k++) begin : g_cmp
    assign hit[k] = (end_cnt_i[k] != '0) && (end_cnt_i[k] == cnt_q);
  end

  assign match_o = |hit;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ir_rx_end_detect.sv
module ir_rx_end_detect
  import ir_end_pkg::*;
#(
  parameter int unsigned TIME_W  = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned NUM_END = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rx_i,
  input  logic                          tick_i,
  input  logic                          leader_i,
  input  logic                          max_en_i,
  input  logic                          low_en_i,
  input  logic [TIME_W-1:0]             max_cycle_i,
  input  logic [TIME_W-1:0]             low_width_i,
  input  logic [NUM_END-1:0][CNT_W-1:0] end_cnt_i,
  input  logic [1:0]                    stat_clr_i,
  output logic                          irq_o,
  output logic                          stat_max_o,
  output logic                          stat_low_o,
  output logic                          busy_o,
  output logic [CNT_W-1:0]              bit_cnt_o
);
  rx_state_e state_q;
  logic      recv, fall, armed_q;
  logic      tmr_clear, max_hit, low_hit, match;
  logic      max_end, low_end, good_max;
  logic      irq_q, stat_max_q, stat_low_q;

  assign recv = (state_q == ST_RECV);

  ir_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .fall_o (fall)
  );

  // both timers restart on leader, on every falling edge, and idle at zero
  assign tmr_clear = leader_i | fall | ~recv;

  ir_tick_timer #(.W(TIME_W)) u_max_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clear),
    .run_i   (tick_i & recv & armed_q),
    .en_i    (max_en_i),
    .thr_i   (max_cycle_i),
    .hit_o   (max_hit)
  );

  ir_tick_timer #(.W(TIME_W)) u_low_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clear),
    .run_i   (tick_i & recv & ~rx_i),
    .en_i    (low_en_i),
    .thr_i   (low_width_i),
    .hit_o   (low_hit)
  );

  ir_bit_counter #(.CNT_W(CNT_W), .NUM_END(NUM_END)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (leader_i),
    .inc_i     (recv & fall & armed_q & ~leader_i),
    .end_cnt_i (end_cnt_i),
    .cnt_o     (bit_cnt_o),
    .match_o   (match)
  );

  // max-cycle wins a same-cycle tie
  assign max_end  = recv & ~leader_i & max_hit;
  assign low_end  = recv & ~leader_i & ~max_hit & low_hit;
  assign good_max = max_end & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_LEADER;
      armed_q <= 1'b0;
    end else if (leader_i) begin
      state_q <= ST_RECV;
      armed_q <= 1'b0;
    end else if (max_end || low_end) begin
      state_q <= ST_WAIT_LEADER;
      armed_q <= 1'b0;
    end else if (recv && fall) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q      <= 1'b0;
      stat_max_q <= 1'b0;
      stat_low_q <= 1'b0;
    end else begin
      irq_q <= good_max | low_end;
      if (good_max)                     stat_max_q <= 1'b1;
      else if (stat_clr_i[CLR_MAX_BIT]) stat_max_q <= 1'b0;
      if (low_end)                      stat_low_q <= 1'b1;
      else if (stat_clr_i[CLR_LOW_BIT]) stat_low_q <= 1'b0;
    end
  end

  assign irq_o      = irq_q;
  assign stat_max_o = stat_max_q;
  assign stat_low_o = stat_low_q;
  assign busy_o     = recv;
endmodule

// File: rtl/ir_rx_end_detect_chk.sv
module ir_rx_end_detect_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             leader_i,
  input logic [1:0]       stat_clr_i,
  input logic             irq_o,
  input logic             stat_max_o,
  input logic             stat_low_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] bit_cnt_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  p_irq_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_max_o || stat_low_o));

  p_irq_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!busy_o && $past(busy_o)));

  p_leader_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leader_i |=> (busy_o && bit_cnt_o == '0));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !leader_i) |=> (!busy_o && !irq_o && $stable(bit_cnt_o)));

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !leader_i |=> (bit_cnt_o == $past(bit_cnt_o) || bit_cnt_o == $past(bit_cnt_o) + 1'b1));

  p_cnt_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt_o == SAT && !leader_i) |=> bit_cnt_o == SAT);

  p_max_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_max_o && !stat_clr_i[0]) |=> stat_max_o);

  p_low_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_low_o && !stat_clr_i[1]) |=> stat_low_o);
endmodule

bind ir_rx_end_detect ir_rx_end_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .leader_i   (leader_i),
  .stat_clr_i (stat_clr_i),
  .irq_o      (irq_o),
  .stat_max_o (stat_max_o),
  .stat_low_o (stat_low_o),
  .busy_o     (busy_o),
  .bit_cnt_o  (bit_cnt_o)
);

// File: tb/ir_rx_end_detect_bench.sv
module ir_rx_end_detect_bench;
  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            rx_i = 1'b1;
  logic            tick_i = 1'b0;
  logic            leader_i = 1'b0;
  logic            max_en_i = 1'b1;
  logic            low_en_i = 1'b1;
  logic [7:0]      max_cycle_i = 8'd10;
  logic [7:0]      low_width_i = 8'd6;
  logic [2:0][7:0] end_cnt_i = '0;
  logic [1:0]      stat_clr_i = 2'b00;
  logic            irq_o, stat_max_o, stat_low_o, busy_o;
  logic [7:0]      bit_cnt_o;

  ir_rx_end_detect u_ir_rx_end_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .tick_i(tick_i),
    .leader_i(leader_i), .max_en_i(max_en_i), .low_en_i(low_en_i),
    .max_cycle_i(max_cycle_i), .low_width_i(low_width_i),
    .end_cnt_i(end_cnt_i), .stat_clr_i(stat_clr_i), .irq_o(irq_o),
    .stat_max_o(stat_max_o), .stat_low_o(stat_low_o), .busy_o(busy_o),
    .bit_cnt_o(bit_cnt_o)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_fall = 0;
  int tphase = 0;
  bit done = 0;

  typedef struct {
    bit       irq;
    bit       by_max;
    logic [7:0] cnt;
    int       thr;
  } exp_t;
  exp_t sb[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    tick_i <= (tphase == 3);
    tphase <= (tphase + 1) % 4;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops an expectation each time reception ends
  bit prev_busy = 0;
  bit prev_irq = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_irq) chk(!irq_o, "R11 irq width", irq_o, 0);
      if (prev_busy && !busy_o) begin
        if (sb.size() == 0) begin
          chk(0, "R2 unexpected end", 1, 0);
        end else begin
          exp_t e;
          int el;
          e = sb.pop_front();
          el = cyc - last_fall;
          chk(irq_o == e.irq, e.by_max ? "R5 irq" : "R8 irq", irq_o, e.irq);
          chk(stat_max_o == (e.irq & e.by_max), "R9 stat_max", stat_max_o, e.irq & e.by_max);
          chk(stat_low_o == (e.irq & !e.by_max), "R9 stat_low", stat_low_o, e.irq & !e.by_max);
          chk(bit_cnt_o == e.cnt, "R3 bit count", bit_cnt_o, e.cnt);
          chk(el >= 4*e.thr-3 && el <= 4*e.thr, "R4 end timing", el, 4*e.thr);
        end
      end
      prev_busy = busy_o;
      prev_irq  = irq_o;
    end
  end

  task automatic leader_pulse();
    @(negedge clk_i); leader_i = 1'b1;
    @(negedge clk_i); leader_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      rx_i = 1'b0; last_fall = cyc + 1;
      repeat (8) @(negedge clk_i);
      rx_i = 1'b1;
      repeat (8) @(negedge clk_i);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk_i); stat_clr_i = 2'b11;
    @(negedge clk_i); stat_clr_i = 2'b00;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy_o; i++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  // nbits data bits; hold_low keeps the line low after the last edge
  task automatic frame(input int nbits, input bit hold_low, input exp_t e);
    clear_flags();
    sb.push_back(e);
    leader_pulse();
    edges(nbits);
    rx_i = 1'b0; last_fall = cyc + 1;
    if (hold_low) begin
      wait_idle();
      rx_i = 1'b1;
    end else begin
      repeat (8) @(negedge clk_i);
      rx_i = 1'b1;
      wait_idle();
    end
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t e;
    end_cnt_i[0] = 8'd8; end_cnt_i[1] = 8'd16; end_cnt_i[2] = 8'd32;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    chk(stat_max_o == 0 && stat_low_o == 0, "R1 flags", {stat_max_o, stat_low_o}, 0);
    chk(bit_cnt_o == 0, "R1 count", bit_cnt_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R5 first comparator
    e = '{irq:1, by_max:1, cnt:8'd8, thr:10};
    frame(8, 0, e);
    // R10 independent W1C
    chk(stat_max_o == 1, "R10 sticky", stat_max_o, 1);
    @(negedge clk_i); stat_clr_i = 2'b10;
    @(negedge clk_i); stat_clr_i = 2'b00;
    chk(stat_max_o == 1, "R10 clr other bit", stat_max_o, 1);
    @(negedge clk_i); stat_clr_i = 2'b01;
    @(negedge clk_i); stat_clr_i = 2'b00;
    chk(stat_max_o == 0, "R10 clr", stat_max_o, 0);

    // R5 third comparator
    e = '{irq:1, by_max:1, cnt:8'd32, thr:10};
    frame(32, 0, e);
    // R6 mismatch: silent return
    e = '{irq:0, by_max:1, cnt:8'd5, thr:10};
    frame(5, 0, e);
    // R7 zero entry never matches a zero count
    end_cnt_i[0] = 8'd0;
    e = '{irq:0, by_max:1, cnt:8'd0, thr:10};
    frame(0, 0, e);
    end_cnt_i[0] = 8'd8;
    // R8 low width ends reception despite mismatched count
    e = '{irq:1, by_max:0, cnt:8'd4, thr:6};
    frame(4, 1, e);
    chk(stat_low_o == 1, "R10 low sticky", stat_low_o, 1);
    // R9 max first when its threshold is shorter
    low_width_i = 8'd10; max_cycle_i = 8'd6;
    e = '{irq:1, by_max:1, cnt:8'd16, thr:6};
    frame(16, 1, e);
    // R9 tie: max wins
    low_width_i = 8'd6;
    e = '{irq:1, by_max:1, cnt:8'd8, thr:6};
    frame(8, 1, e);
    // R9 tie with mismatch: max ends silently
    e = '{irq:0, by_max:1, cnt:8'd3, thr:6};
    frame(3, 1, e);
    max_cycle_i = 8'd10;
    // R3 saturation
    end_cnt_i[2] = 8'd255;
    e = '{irq:1, by_max:1, cnt:8'd255, thr:10};
    frame(300, 0, e);
    end_cnt_i[2] = 8'd32;

    // R4 zero threshold never ends reception
    low_en_i = 1'b0; max_cycle_i = 8'd0;
    leader_pulse();
    edges(3);
    repeat (200) @(negedge clk_i);
    chk(busy_o == 1, "R4 zero threshold", busy_o, 1);
    // R4 disabled
    max_cycle_i = 8'd10; max_en_i = 1'b0;
    leader_pulse();
    edges(3);
    repeat (200) @(negedge clk_i);
    chk(busy_o == 1, "R4 max disabled", busy_o, 1);
    chk(irq_o == 0, "R4 no irq", irq_o, 0);
    max_en_i = 1'b1; low_en_i = 1'b1;

    // R2 leader mid-frame restarts the count
    clear_flags();
    leader_pulse();
    edges(6);
    chk(bit_cnt_o == 5, "R3 partial count", bit_cnt_o, 5);
    e = '{irq:1, by_max:1, cnt:8'd16, thr:10};
    frame(16, 0, e);
    // R2 idle holds
    repeat (50) @(negedge clk_i);
    chk(busy_o == 0 && bit_cnt_o == 16, "R2 idle hold", bit_cnt_o, 16);
    chk(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule